// File: doc/BRIEF.md
# LIN Sync-Field Bit-Period Meter

This block measures the real bit time of an incoming LIN frame. Once an external break detector has seen the sync break, it pulses a strobe into this block. The block then watches the synchronized receive line for the falling edges of the 0x55 sync byte. That byte is a start bit followed by data bits that alternate, least significant first, so its falling edges come every two bit times.

The block stamps the edges with a free-running timer value supplied from outside. It keeps the timer value seen at the first falling edge and at the fifth falling edge, and raises a separate sticky event flag for each. These two edges lie eight bit times apart. The block therefore reports the difference of the two stamps, shifted right by three, as the measured bit period, and marks it with a one-cycle valid pulse.

After the fifth edge the block disarms until the next break strobe. Software or a baud-tuning stage reads the period and clears the flags by writing one to the clear inputs.

Top module: `lin_sync_meter`

## Requirements
- R1: After reset, `first_evt`, `fifth_evt` and `period_vld` are 0, and `t_first`, `t_fifth` and `bit_period` are all zeros.
- R2: While not armed (after reset and before any `brk_seen` pulse), falling edges on `rx_in` leave the flags, the captures and `period_vld` unchanged.
- R3: On the first falling edge after a `brk_seen` pulse, `t_first` takes the value `stamp` holds at the third rising clock edge after `rx_in` goes low (two synchronizer stages plus the edge register), and `first_evt` becomes 1 at that same edge.
- R4: On the fifth falling edge after arming, `t_fifth` takes the `stamp` value at the third rising edge after that fall, and `fifth_evt` becomes 1 at that same edge.
- R5: `bit_period` equals ((`t_fifth` − `t_first`) modulo 2^TW) shifted right by 3, so a timer wrap between the two edges still gives the right result.
- R6: `period_vld` is high for exactly one cycle per measurement, at the same edge that loads `t_fifth`.
- R7: The second, third and fourth falling edges neither load a capture nor set a flag.
- R8: Each flag stays at 1 until its own clear input (`clr_first` or `clr_fifth`) is high at a clock edge. That clear resets only its own flag.
- R9: A `brk_seen` pulse while armed restarts the edge count, so the next falling edge is treated as the first.
- R10: After the fifth edge the block disarms. A further 0x55 byte with no new `brk_seen` leaves the captures, the flags and `period_vld` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Asynchronous LIN receive line, idle high |
| brk_seen | input | 1 | One-cycle strobe from the break detector; arms the block |
| stamp | input | TW | Free-running timer value |
| clr_first | input | 1 | Write-one-to-clear for `first_evt` |
| clr_fifth | input | 1 | Write-one-to-clear for `fifth_evt` |
| first_evt | output | 1 | Sticky flag: first edge captured |
| fifth_evt | output | 1 | Sticky flag: fifth edge captured |
| t_first | output | TW | Timer value captured at the first edge |
| t_fifth | output | TW | Timer value captured at the fifth edge |
| bit_period | output | TW-3 | Measured bit period in timer ticks |
| period_vld | output | 1 | One-cycle pulse when `bit_period` is updated |

## Verification
The bench builds the block with TW = 8 and two synchronizer stages. An 8-bit timer wraps every 256 cycles, so a sweep of bit times from 1 to 34 cycles makes many measurements cross the wrap point. The sweep also reaches spans of 256 ticks and more, where the 5-bit period folds to 0, 1 and 2. With such a short timer, every wrap phase and the modulo corner are covered in a few thousand cycles.

// File: rtl/lin_sync_meter.sv
module lin_sync_meter #(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_in,
  input  logic          brk_seen,
  input  logic [TW-1:0] stamp,
  input  logic          clr_first,
  input  logic          clr_fifth,
  output logic          first_evt,
  output logic          fifth_evt,
  output logic [TW-1:0] t_first,
  output logic [TW-1:0] t_fifth,
  output logic [TW-4:0] bit_period,
  output logic          period_vld
);
  localparam int SHIFT = 3;
  localparam int LAST  = 4;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s, rx_prev, fall;
  logic                   armed;
  logic [2:0]             edge_cnt;
  logic                   hit, is_first, is_last;
  logic [TW-1:0]          span;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= rx_in;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
    end
  endgenerate

  assign rx_s     = sync_q[SYNC_STAGES-1];
  assign fall     = rx_prev & ~rx_s;
  assign hit      = armed & fall & ~brk_seen;
  assign is_first = hit && (edge_cnt == 3'd0);
  assign is_last  = hit && (edge_cnt == 3'(LAST));
  assign span     = stamp - t_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev    <= 1'b1;
      armed      <= 1'b0;
      edge_cnt   <= '0;
      t_first    <= '0;
      t_fifth    <= '0;
      bit_period <= '0;
      period_vld <= 1'b0;
      first_evt  <= 1'b0;
      fifth_evt  <= 1'b0;
    end else begin
      rx_prev    <= rx_s;
      period_vld <= is_last;
      if (brk_seen) begin
        armed    <= 1'b1;
        edge_cnt <= '0;
      end else if (hit) begin
        edge_cnt <= edge_cnt + 3'd1;
        if (is_last) armed <= 1'b0;
      end
      if (is_first) t_first <= stamp;
      if (is_last) begin
        t_fifth    <= stamp;
        bit_period <= span[TW-1:SHIFT];
      end
      first_evt <= is_first | (first_evt & ~clr_first);
      fifth_evt <= is_last  | (fifth_evt & ~clr_fifth);
    end
  end
endmodule

module lin_sync_meter_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_first,
  input logic          first_evt,
  input logic          fifth_evt,
  input logic [TW-1:0] t_first,
  input logic [TW-1:0] t_fifth,
  input logic [TW-4:0] bit_period,
  input logic          period_vld
);
  logic [TW-1:0] diff;
  assign diff = t_fifth - t_first;

  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    period_vld |=> !period_vld); // R6
  AST_VLD_WITH_FIFTH: assert property (@(posedge clk) disable iff (!rst_n)
    period_vld |-> fifth_evt && !$stable(t_fifth) || period_vld && fifth_evt && $past(t_fifth) == t_fifth); // R4
  AST_PERIOD_MATH: assert property (@(posedge clk) disable iff (!rst_n)
    period_vld |-> bit_period == diff[TW-1:3]); // R5
  AST_T1_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(t_first) |-> first_evt); // R3
  AST_T2_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(t_fifth) |-> period_vld && fifth_evt); // R6
  AST_FIRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    first_evt && !clr_first |=> first_evt); // R8
endmodule

bind lin_sync_meter lin_sync_meter_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_first(clr_first),
  .first_evt(first_evt), .fifth_evt(fifth_evt),
  .t_first(t_first), .t_fifth(t_fifth),
  .bit_period(bit_period), .period_vld(period_vld)
);

// File: tb/tb_lin_sync_meter.sv
module tb_lin_sync_meter;
  localparam int TW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_in = 1'b1, brk_seen = 1'b0, clr_first = 1'b0, clr_fifth = 1'b0;
  logic [TW-1:0] stamp;
  logic first_evt, fifth_evt, period_vld;
  logic [TW-1:0] t_first, t_fifth;
  logic [TW-4:0] bit_period;
  int n_chk = 0, n_fail = 0, vld_cnt = 0;
  logic [TW-1:0] s1, s5;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) stamp <= '0;
    else        stamp <= stamp + 1'b1;

  always @(negedge clk) if (period_vld) vld_cnt++;

  lin_sync_meter #(.TW(TW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .brk_seen(brk_seen), .stamp(stamp),
    .clr_first(clr_first), .clr_fifth(clr_fifth), .first_evt(first_evt),
    .fifth_evt(fifth_evt), .t_first(t_first), .t_fifth(t_fifth),
    .bit_period(bit_period), .period_vld(period_vld));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_brk();
    brk_seen = 1'b1;
    @(negedge clk);
    brk_seen = 1'b0;
  endtask

  // Sends the first nbits bits of start + 0x55 (LSB first) + stop, bit time b cycles.
  task automatic send(input int b, input int nbits, input bit mid_chk);
    for (int i = 0; i < nbits; i++) begin
      if (mid_chk && i == 4) begin
        chk(first_evt == 1'b1, "R3 first flag mid-field", int'(first_evt), 1);
        chk(fifth_evt == 1'b0, "R7 no fifth flag on edges 2-4", int'(fifth_evt), 0);
      end
      rx_in = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : 1'(i % 2);
      if (i == 0) s1 = stamp;
      if (i == 8) s5 = stamp;
      repeat (b) @(negedge clk);
    end
    rx_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [TW-1:0] keep1, keep5;
    int v0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!first_evt && !fifth_evt && !period_vld, "R1 flags after reset", int'({first_evt, fifth_evt, period_vld}), 0);
    chk(t_first == 0 && t_fifth == 0 && bit_period == 0, "R1 captures after reset", int'(t_first), 0);

    // R2: sync byte before any break strobe
    send(3, 10, 1'b0);
    chk(!first_evt && !fifth_evt, "R2 flags stay clear unarmed", int'({first_evt, fifth_evt}), 0);
    chk(t_first == 0 && t_fifth == 0 && vld_cnt == 0, "R2 no capture unarmed", int'(t_first), 0);

    // Sweep bit times; 8-bit timer wraps often, spans >= 256 fold the period
    for (int b = 1; b <= 34; b++) begin
      v0 = vld_cnt;
      pulse_brk();
      send(b, 10, b >= 2);
      chk(t_first == TW'(s1 + 2), $sformatf("R3 t_first b=%0d", b), int'(t_first), int'(TW'(s1 + 2)));
      chk(t_fifth == TW'(s5 + 2), $sformatf("R4 t_fifth b=%0d", b), int'(t_fifth), int'(TW'(s5 + 2)));
      chk(first_evt && fifth_evt, $sformatf("R4 flags set b=%0d", b), int'({first_evt, fifth_evt}), 3);
      chk(int'(bit_period) == ((8 * b) % 256) >> 3, $sformatf("R5 period b=%0d", b),
          int'(bit_period), ((8 * b) % 256) >> 3);
      chk(vld_cnt == v0 + 1, $sformatf("R6 one valid pulse b=%0d", b), vld_cnt - v0, 1);
      clr_first = 1'b1;
      @(negedge clk);
      clr_first = 1'b0;
      @(negedge clk);
      chk(!first_evt && fifth_evt, "R8 clear first only", int'({first_evt, fifth_evt}), 1);
      clr_fifth = 1'b1;
      @(negedge clk);
      clr_fifth = 1'b0;
      @(negedge clk);
      chk(!fifth_evt, "R8 clear fifth", int'(fifth_evt), 0);
    end

    // R10: no new break, another sync byte is ignored
    keep1 = t_first; keep5 = t_fifth; v0 = vld_cnt;
    send(5, 10, 1'b0);
    chk(t_first == keep1 && t_fifth == keep5, "R10 captures unchanged", int'(t_first), int'(keep1));
    chk(!first_evt && !fifth_evt && vld_cnt == v0, "R10 no flags or pulse", int'({first_evt, fifth_evt}), 0);

    // R9: break while armed restarts the count
    pulse_brk();
    send(6, 5, 1'b0);
    chk(first_evt == 1'b1, "R9 partial frame first flag", int'(first_evt), 1);
    clr_first = 1'b1;
    @(negedge clk);
    clr_first = 1'b0;
    pulse_brk();
    v0 = vld_cnt;
    send(7, 10, 1'b0);
    chk(t_first == TW'(s1 + 2), "R9 restarted t_first", int'(t_first), int'(TW'(s1 + 2)));
    chk(t_fifth == TW'(s5 + 2), "R9 restarted t_fifth", int'(t_fifth), int'(TW'(s5 + 2)));
    chk(int'(bit_period) == 7 && vld_cnt == v0 + 1, "R9 restarted period", int'(bit_period), 7);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule